// File: doc/BRIEF.md
# Interrupt-Terminated Program Memory Write Controller

This block sequences the write of one word into on-chip non-volatile program memory. When the core issues a table-write request and the programming supply is present, the controller enters a long write. It stalls instruction execution and holds the memory write strobe, the latched address and the latched data steady. The write has no fixed length. Only an interrupt source whose enable and flag are both set ends it, or a reset.

When the write ends, the global interrupt disable bit decides what follows. With the bit clear, the core is asked to branch to the interrupt vector. With the bit set, execution resumes in line. In that case a core-class source, but never the peripheral group, has its flag cleared by a pulse from this block. A request made while an enabled interrupt is already pending is turned into a NOP. A request made without the programming supply is a two-cycle write that leaves memory alone.

A saturating counter measures the length of each long write. It raises a sticky flag when a write ends before the minimum programming time.

Top module: `ltw_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `stall`, `mem_we`, `vec_req`, `core_clr`, `abort_nop` and `underprog` are all 0.
- R2: A `wr_req` in idle with `vpp_ok`=1 and no enabled flag set raises `stall` and `mem_we` from the next cycle. `mem_addr`/`mem_data` carry the values present at the request and stay stable until the write ends.
- R3: The long write ends at the first clock edge where some source has both its enable and its flag at 1, and `stall`/`mem_we` are 0 from the next cycle. A flag without its enable, or an enable without its flag, leaves the write running.
- R4: On ending a long write, `vec_req` pulses for exactly one cycle if `glob_dis` was 0 at the ending edge, and stays 0 if it was 1.
- R5: On ending a long write with `glob_dis`=1, `core_clr` pulses for one cycle with only the bit of the highest-priority core source whose enable and flag are both set. Bit 0 is the external pin, bit 1 timer overflow and bit 2 timer clock input, and a lower index wins. With `glob_dis`=0, `core_clr` stays 0.
- R6: The peripheral group never produces a flag-clear: a write ended only by it gives `core_clr`=0 for either value of `glob_dis`.
- R7: A `wr_req` in idle while any enabled flag is set gives a one-cycle `abort_nop` pulse and no stall, write strobe or vector. In the same cycle `core_clr` carries the highest-priority enabled pending core source, for either `glob_dis` value.
- R8: A `wr_req` in idle with `vpp_ok`=0 and nothing pending stalls for exactly one cycle and never raises `mem_we`.
- R9: `underprog` becomes 1 after a long write whose stall lasted fewer than `MIN_PROG_CYC` cycles. It stays 0 if the stall lasted `MIN_PROG_CYC` cycles or more, and only reset clears it.
- R10: Reset in the middle of a long write returns the block to idle: `stall` and `mem_we` drop and no `vec_req` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Table-write request, one cycle |
| wr_addr | input | ADDR_W | Program memory word address |
| wr_data | input | DATA_W | Word to program |
| vpp_ok | input | 1 | Programming supply present |
| glob_dis | input | 1 | Global interrupt disable (1 = no vectoring) |
| core_en | input | 3 | Core source enables, bit 0 highest priority |
| core_flag | input | 3 | Core source flags |
| per_en | input | 1 | Peripheral group enable |
| per_flag | input | 1 | Peripheral group flag |
| stall | output | 1 | Halt instruction execution |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | ADDR_W | Latched write address |
| mem_data | output | DATA_W | Latched write data |
| vec_req | output | 1 | Branch to interrupt vector, one-cycle pulse |
| core_clr | output | 3 | Core flag clear pulses |
| abort_nop | output | 1 | Request turned into a NOP, one-cycle pulse |
| underprog | output | 1 | Sticky: a write ended before the minimum time |

## Verification
Assertions check on every cycle these properties:
- the write strobe never appears without a stall;
- the latched address and data hold through a long write;
- the write neither ends early nor outlives a qualifying interrupt;
- a vector request only follows a write that ended with global disable clear;
- flag-clear pulses are at most one-hot;
- a short write lasts one cycle;
- the underprogrammed flag is sticky.

Only the bench scenarios can show which flag is cleared for each mix of enables, flags and disable bit, and the abort path under every pending pattern. The same holds for the exact boundary of the programming-time check and the effect of a reset in the middle of a write.

// File: rtl/ltw_pkg.sv
package ltw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LONG  = 2'd1,
      ST_SHORT = 2'd2
   } ltw_state_e;

   localparam int CORE_SRCS = 3;
endpackage

// File: rtl/ltw_prio.sv
module ltw_prio #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] sel
);
   generate
      if (N < 1) begin : g_bad_n
         $error("ltw_prio: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (i == 0) begin : g_top
            assign sel[i] = req[i];
         end else begin : g_rest
            assign sel[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

   always_comb begin
      a_r5_sel_onehot : assert ($onehot0(sel));
   end
endmodule

// File: rtl/ltw_prog_timer.sv
module ltw_prog_timer #(
   parameter int MIN_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic early
);
   localparam int CW = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
   localparam logic [CW-1:0] SAT = CW'(MIN_CYC - 1);

   logic [CW-1:0] cnt;

   generate
      if (MIN_CYC < 2) begin : g_bad_min
         $error("ltw_prog_timer: MIN_CYC must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= '0;
      end else if (run && cnt != SAT) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign early = (cnt < SAT);

   a_r9_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= SAT);
endmodule

// File: rtl/ltw_ctrl.sv
module ltw_ctrl #(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 16,
   parameter int MIN_PROG_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              vpp_ok,
   input  logic              glob_dis,
   input  logic [2:0]        core_en,
   input  logic [2:0]        core_flag,
   input  logic              per_en,
   input  logic              per_flag,
   output logic              stall,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              vec_req,
   output logic [2:0]        core_clr,
   output logic              abort_nop,
   output logic              underprog
);
   import ltw_pkg::*;

   localparam int NC = CORE_SRCS;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ltw_ctrl: widths must be positive");
      end
   endgenerate

   ltw_state_e        state_q;
   logic [NC-1:0]     core_hit, core_sel;
   logic              per_hit, any_hit, early;
   logic              start_long;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              vec_q, abort_q, under_q;
   logic [NC-1:0]     clr_q;

   assign core_hit   = core_en & core_flag;
   assign per_hit    = per_en & per_flag;
   assign any_hit    = (|core_hit) | per_hit;
   assign start_long = (state_q == ST_IDLE) && wr_req && !any_hit && vpp_ok;

   ltw_prio #(.N(NC)) u_prio (
      .req (core_hit),
      .sel (core_sel)
   );

   ltw_prog_timer #(.MIN_CYC(MIN_PROG_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_long),
      .run   (state_q == ST_LONG),
      .early (early)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         vec_q   <= 1'b0;
         abort_q <= 1'b0;
         clr_q   <= '0;
         under_q <= 1'b0;
      end else begin
         vec_q   <= 1'b0;
         abort_q <= 1'b0;
         clr_q   <= '0;
         unique case (state_q)
            ST_IDLE: begin
               if (wr_req) begin
                  if (any_hit) begin
                     abort_q <= 1'b1;
                     clr_q   <= core_sel;
                  end else if (vpp_ok) begin
                     state_q <= ST_LONG;
                     addr_q  <= wr_addr;
                     data_q  <= wr_data;
                  end else begin
                     state_q <= ST_SHORT;
                  end
               end
            end
            ST_LONG: begin
               if (any_hit) begin
                  state_q <= ST_IDLE;
                  vec_q   <= !glob_dis;
                  clr_q   <= glob_dis ? core_sel : '0;
                  if (early) under_q <= 1'b1;
               end
            end
            ST_SHORT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign stall     = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_LONG);
   assign mem_addr  = addr_q;
   assign mem_data  = data_q;
   assign vec_req   = vec_q;
   assign core_clr  = clr_q;
   assign abort_nop = abort_q;
   assign underprog = under_q;

   a_r2_we_in_stall : assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> stall);
   a_r2_hold_word : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> ($stable(mem_addr) && $stable(mem_data)));
   a_r3_no_early_end : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !any_hit) |=> mem_we);
   a_r3_end_on_hit : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && any_hit) |=> !stall);
   a_r4_vec_source : assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> ($past(mem_we) && !$past(glob_dis)));
   a_r5_clr_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_clr));
   a_r7_abort_no_stall : assert property (@(posedge clk) disable iff (!rst_n)
      abort_nop |-> (!stall && !vec_req));
   a_r8_short_one : assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !mem_we) |=> !stall);
   a_r9_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      underprog |=> underprog);
endmodule

// File: tb/ltw_ctrl_tb_top.sv
module ltw_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int MIN = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          vpp_ok = 1'b0;
   logic          glob_dis = 1'b0;
   logic [2:0]    core_en = '0, core_flag = '0;
   logic          per_en = 1'b0, per_flag = 1'b0;
   logic          stall, mem_we, vec_req, abort_nop, underprog;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic [2:0]    core_clr;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ltw_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MIN_PROG_CYC(MIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .vpp_ok(vpp_ok), .glob_dis(glob_dis),
      .core_en(core_en), .core_flag(core_flag), .per_en(per_en),
      .per_flag(per_flag), .stall(stall), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_data(mem_data), .vec_req(vec_req),
      .core_clr(core_clr), .abort_nop(abort_nop), .underprog(underprog)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] top_core(input logic [2:0] v);
      if (v[0]) return 3'b001;
      if (v[1]) return 3'b010;
      if (v[2]) return 3'b100;
      return 3'b000;
   endfunction

   task automatic set_src(input logic [8:0] c);
      core_en   = c[2:0];
      core_flag = c[5:3];
      per_en    = c[6];
      per_flag  = c[7];
      glob_dis  = c[8];
   endtask

   task automatic start_long(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      set_src('0); vpp_ok = 1'b1; wr_addr = a; wr_data = d; wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0; wr_addr = ~a; wr_data = ~d;
      chk("R2 stall", stall, 1);
      chk("R2 mem_we", mem_we, 1);
      chk("R2 addr", mem_addr, a);
      chk("R2 data", mem_data, d);
   endtask

   task automatic quiet_end();
      set_src(9'b1_1100_0000);
      @(negedge clk);
      chk("R6 quiet end stall", stall, 0);
      chk("R6 quiet end clr", core_clr, 0);
      set_src('0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 stall", stall, 0); chk("R1 we", mem_we, 0);
      chk("R1 under", underprog, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 stall", stall, 0); chk("R1 vec", vec_req, 0);
      chk("R1 clr", core_clr, 0); chk("R1 abort", abort_nop, 0);

      // Termination sweep over all enable/flag/disable patterns
      for (int c = 0; c < 512; c++) begin
         logic [8:0] cv;
         logic [2:0] hit;
         logic       term;
         cv   = 9'(c);
         hit  = cv[2:0] & cv[5:3];
         term = (|hit) | (cv[6] & cv[7]);
         start_long(AW'(c * 7 + 3), DW'(c * 13 + 5));
         repeat (MIN + 1) @(negedge clk);
         chk("R2 held addr", mem_addr, AW'(c * 7 + 3));
         set_src(cv);
         @(negedge clk);
         if (term) begin
            chk("R3 ended", stall, 0);
            chk("R3 we off", mem_we, 0);
            chk("R4 vec", vec_req, !cv[8]);
            chk(cv[8] ? "R5 clr gd=1" : "R5 clr gd=0", core_clr,
                cv[8] ? top_core(hit) : 3'b000);
            if (hit == 0) chk("R6 per no clr", core_clr, 0);
            set_src('0);
            @(negedge clk);
            chk("R4 vec pulse", vec_req, 0);
            chk("R5 clr pulse", core_clr, 0);
         end else begin
            @(negedge clk);
            chk("R3 still running", mem_we, 1);
            quiet_end();
         end
      end
      chk("R9 no underprog", underprog, 0);

      // Abort sweep
      for (int c = 0; c < 512; c++) begin
         logic [8:0] cv;
         logic [2:0] hit;
         cv  = 9'(c);
         hit = cv[2:0] & cv[5:3];
         @(negedge clk);
         set_src(cv); vpp_ok = 1'b1; wr_req = 1'b1;
         @(negedge clk);
         wr_req = 1'b0;
         if ((|hit) || (cv[6] & cv[7])) begin
            chk("R7 abort", abort_nop, 1);
            chk("R7 no stall", stall, 0);
            chk("R7 no vec", vec_req, 0);
            chk("R7 clr", core_clr, top_core(hit));
            set_src('0);
            @(negedge clk);
            chk("R7 abort pulse", abort_nop, 0);
         end else begin
            chk("R2 started", mem_we, 1);
            repeat (MIN) @(negedge clk);
            quiet_end();
         end
      end

      // Short write without programming supply
      @(negedge clk);
      set_src('0); vpp_ok = 1'b0; wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
      chk("R8 stall", stall, 1); chk("R8 no we", mem_we, 0);
      @(negedge clk);
      chk("R8 done", stall, 0); chk("R8 no we", mem_we, 0);

      // Minimum time boundary: MIN stall cycles is enough
      start_long(16'h1234, 16'hABCD);
      repeat (MIN - 1) @(negedge clk);
      quiet_end();
      chk("R9 exact min", underprog, 0);
      // MIN-1 stall cycles is too short
      start_long(16'h4321, 16'hDCBA);
      repeat (MIN - 2) @(negedge clk);
      quiet_end();
      chk("R9 early set", underprog, 1);
      start_long(16'h0001, 16'h0002);
      repeat (MIN + 2) @(negedge clk);
      quiet_end();
      chk("R9 sticky", underprog, 1);

      // Reset during long write
      start_long(16'h5555, 16'hAAAA);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 stall", stall, 0); chk("R10 we", mem_we, 0);
      chk("R9 reset clears", underprog, 0);
      rst_n = 1'b1;
      set_src(9'b0_0000_1001);
      @(negedge clk);
      chk("R10 no vec", vec_req, 0); chk("R10 idle", stall, 0);
      set_src('0);
      @(negedge clk);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule